// File: doc/BRIEF.md
# Fixed-Priority Shared Memory Arbiter

This block decides which of seven clients may use a single shared RAM during each memory cycle. Each client raises an active-low request line once its address and data are valid. The arbiter brings all request lines into its own clock domain through a chain of synchronizing flops. Whenever the cycle-start strobe is high on a clock edge, it picks one winner and drives that client's active-low grant line. The low grant enables the winner's bus drivers for the rest of the cycle.

The ranking is fixed. A client that won the previous memory cycle is barred from winning the next one. The floating-point client is the one exception: it may hold the memory for a second cycle in a row when no client ranked above it is asking. When no client is eligible, the arbiter grants nothing and raises an output that turns off the bus transceivers, so no memory access happens in that cycle. A client drops its request after it sees its grant. The grant is withdrawn at the next strobe, which completes the two-wire handshake.

Top module: `mem_arbiter`

## Requirements
- R1: Requester index k uses bit k of `req_n_i` and `grant_n_o`. The indices in rank order are 0 FFT engine, 1 filter channel 1, 2 filter channel 2, 3 refresh, 4 display, 5 floating-point unit, 6 CPU. Among the eligible requesters, the lowest index wins.
- R2: A request is a 0 on `req_n_i[k]`. A grant is a 0 on `grant_n_o[k]`. Every other grant bit reads 1.
- R3: Requests pass through two synchronizing flops. The strobe edge sees a request only if the request was driven before the two clock edges that come before that strobe edge.
- R4: A new decision is taken only on a clock edge where `cyc_start_i` is 1. `grant_n_o` and `xcvr_off_o` do not change between strobes.
- R5: At most one bit of `grant_n_o` is low at any time.
- R6: A requester other than index 5 that holds the current grant is not eligible at the next strobe. Another requester wins instead, or the arbiter goes idle.
- R7: Index 5 may win a second consecutive cycle only when none of indices 0 to 4 is requesting. Otherwise it is barred, like any other requester.
- R8: When no requester is eligible at a strobe, all grant bits go to 1 and `xcvr_off_o` goes to 1. The previous winner is then forgotten, so it can win at the strobe after that.
- R9: While `rst` is 1, `grant_n_o` is all ones, `xcvr_off_o` is 1, no previous winner is recorded, and the synchronizer holds "no request".
- R10: `xcvr_off_o` is 0 exactly when one grant bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start_i | input | 1 | Memory cycle start strobe; arbitration happens on this edge |
| req_n_i | input | 7 | Active-low requests, index 0 highest priority |
| grant_n_o | output | 7 | Active-low registered grants, at most one low |
| xcvr_off_o | output | 1 | High when no grant is issued; disables the bus transceivers |

## Verification
The bench puts the whole set of requesters on the bus and steps through three strobes. If the back-to-back ban is missing, FFT wins every time. If the ban is applied without regard to rank, filter channel 1 never gets through. When only refresh keeps requesting, the middle cycle must be idle: a design that forgets to clear the previous winner stays idle forever, and one without the ban grants refresh three times in a row. The floating-point exemption is tested both alone and with filter channel 1 competing, where the correct sequence alternates between the two. A request raised on the strobe edge itself must not be seen, which catches a synchronizer that is too short. Changing the requests between strobes must leave the grant untouched.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_CLIENTS = 7;
  localparam int SYNC_DEPTH  = 2;
  // client ranking, 0 is served first
  localparam int CL_FFT  = 0;
  localparam int CL_FLT1 = 1;
  localparam int CL_FLT2 = 2;
  localparam int CL_RFSH = 3;
  localparam int CL_DISP = 4;
  localparam int CL_FPU  = 5;
  localparam int CL_CPU  = 6;
endpackage

// File: rtl/arb_req_sync.sv
module arb_req_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req_n_i,
  output logic [W-1:0] req_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= req_n_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // active-high internal request
  assign req_o = ~stg_q[STAGES-1];
endmodule

// File: rtl/arb_mask.sv
module arb_mask #(
  parameter int W      = 7,
  parameter int EXEMPT = 5
) (
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] elig_o
);
  localparam logic [W-1:0] ABOVE = (W'(1) << EXEMPT) - W'(1);

  logic         above_pend;
  logic [W-1:0] ban;

  always_comb begin
    above_pend = |(req_i & ABOVE);
    ban        = last_i;
    if (!above_pend) ban[EXEMPT] = 1'b0;
    elig_o     = req_i & ~ban;
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int W = 7
) (
  input  logic [W-1:0] elig_i,
  output logic [W-1:0] win_o
);
  logic [W-1:0] taken;

  always_comb begin
    win_o = '0;
    taken = '0;
    for (int i = 0; i < W; i++) begin
      win_o[i] = elig_i[i] & ~(|taken);
      taken[i] = elig_i[i];
    end
  end
endmodule

// File: rtl/mem_arbiter.sv
module mem_arbiter #(
  parameter int NREQ        = arb_pkg::NUM_CLIENTS,
  parameter int SYNC_STAGES = arb_pkg::SYNC_DEPTH,
  parameter int EXEMPT_IDX  = arb_pkg::CL_FPU
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_start_i,
  input  logic [NREQ-1:0] req_n_i,
  output logic [NREQ-1:0] grant_n_o,
  output logic            xcvr_off_o
);
  localparam logic [NREQ-1:0] EXM = NREQ'(1) << EXEMPT_IDX;

  logic [NREQ-1:0] req_s, elig, win;
  logic [NREQ-1:0] grant_n_q;
  logic            xcvr_off_q;

  arb_req_sync #(.W(NREQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_n_i(req_n_i), .req_o(req_s)
  );

  // current grant doubles as the previous-winner record
  arb_mask #(.W(NREQ), .EXEMPT(EXEMPT_IDX)) u_mask (
    .req_i(req_s), .last_i(~grant_n_q), .elig_o(elig)
  );

  arb_pick #(.W(NREQ)) u_pick (
    .elig_i(elig), .win_o(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_n_q  <= '1;
      xcvr_off_q <= 1'b1;
    end else if (cyc_start_i) begin
      grant_n_q  <= ~win;
      xcvr_off_q <= ~|elig;
    end
  end

  assign grant_n_o  = grant_n_q;
  assign xcvr_off_o = xcvr_off_q;

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~grant_n_o));

  // R10
  xcvr_match_chk: assert property (@(posedge clk) disable iff (rst)
    xcvr_off_o == (grant_n_o == '1));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_start_i |=> $stable(grant_n_o) && $stable(xcvr_off_o));

  // R6
  no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start_i |=> ((~grant_n_o & ~$past(grant_n_o) & ~EXM) == '0));
endmodule

// File: tb/mem_arbiter_bench.sv
`timescale 1ns/1ps
module mem_arbiter_bench;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst;
  logic         cyc_start;
  logic [N-1:0] req_n;
  logic [N-1:0] grant_n;
  logic         xcvr_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mem_arbiter u_mem_arbiter (
    .clk(clk), .rst(rst), .cyc_start_i(cyc_start),
    .req_n_i(req_n), .grant_n_o(grant_n), .xcvr_off_o(xcvr_off)
  );

  task automatic expect_state(input int idx, input string tag);
    logic [N-1:0] eg;
    logic         ex;
    eg = (idx < 0) ? '1 : ~(N'(1) << idx);
    ex = (idx < 0);
    checks++;
    if (grant_n !== eg || xcvr_off !== ex) begin
      fails++;
      $display("FAIL %s: grant_n=%b xcvr_off=%b expected grant_n=%b xcvr_off=%b",
               tag, grant_n, xcvr_off, eg, ex);
    end
  endtask

  // drive requests and let them cross the two synchronizer flops
  task automatic set_req(input logic [N-1:0] m);
    @(negedge clk) req_n = ~m;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe_expect(input int idx, input string tag);
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    expect_state(idx, tag);
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc_start = 1'b0; req_n = '1;
    repeat (3) @(negedge clk);
    expect_state(-1, "R9 in reset");
    rst = 1'b0;
    @(negedge clk);
    expect_state(-1, "R9 after reset");
  endtask

  task automatic t_single;
    for (int k = 0; k < N; k++) begin
      set_req(N'(1) << k);
      strobe_expect(k, "R1 R2 single requester");
    end
  endtask

  task automatic t_priority;
    set_req('1);
    strobe_expect(0, "R1 all request");
    strobe_expect(1, "R6 FFT barred after win");
    strobe_expect(0, "R6 FFT back after gap");
  endtask

  task automatic t_ban;
    set_req(N'(1) << 3);
    strobe_expect(3, "R1 refresh alone");
    strobe_expect(-1, "R6 R8 refresh barred, idle");
    strobe_expect(3, "R8 winner forgotten after idle");
  endtask

  task automatic t_exempt;
    set_req(N'(1) << 5);
    strobe_expect(5, "R7 fpu first");
    strobe_expect(5, "R7 fpu second in a row");
    set_req(7'b1100000);
    strobe_expect(5, "R7 fpu over cpu again");
    set_req(7'b0100010);
    strobe_expect(1, "R7 fpu barred with filter1 pending");
    strobe_expect(5, "R6 filter1 barred, fpu wins");
    strobe_expect(1, "R7 fpu barred again with higher pending");
  endtask

  task automatic t_hold;
    set_req(N'(1) << 2);
    strobe_expect(2, "R1 filter2");
    @(negedge clk) req_n = ~7'b0000001;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      expect_state(2, "R4 grant held without strobe");
    end
  endtask

  task automatic t_sync;
    set_req('0);
    strobe_expect(-1, "R8 no requests");
    @(negedge clk) begin req_n = ~(N'(1) << 4); cyc_start = 1'b1; end
    @(negedge clk) cyc_start = 1'b0;
    expect_state(-1, "R3 request not yet synchronized");
    @(negedge clk);
    strobe_expect(4, "R3 request seen after sync");
  endtask

  initial begin
    t_reset();
    t_single();
    t_priority();
    t_ban();
    t_exempt();
    t_hold();
    t_sync();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule